// File: doc/BRIEF.md
# Selectable Processor Clock Divider Path

This block derives the processor clock from two reference clocks: a crystal reference and a PLL output. Both references, and the processor clock produced, are represented as clock-enable pulse trains inside one system clock domain. A pulse on an input means one edge of that reference. A pulse on the output means one edge of the processor clock. Because of this, the whole path is ordinary synchronous logic.

Three stages make up the path:
- A source selector takes either the PLL pulses or the crystal pulses.
- A post-divider passes one of every 1, 2, 3 or 2N selected pulses.
- An output selector drives the processor clock from either the divider or the raw crystal pulses.

Software sets the path through two 32-bit control words on a simple register port. The divide-ratio code and the N field are sampled only at the end of a divided period. A ratio change therefore never shortens or stretches a period already in progress.

Top module: `cpu_clk_path`

## Requirements
- R1: After reset, both control words read 0, and `cpu_tick` equals `xtal_tick` in every cycle.
- R2: A write to offset 0x00 (divider word) or offset 0x40 (main word) stores all 32 bits, and a read returns them unchanged. At any other offset a write has no effect and a read returns 0.
- R3: Main word bit 0 picks the source that feeds the divider: 1 selects `pll_tick` and 0 selects `xtal_tick`.
- R4: When main word bit 7 is 0, `cpu_tick` equals `xtal_tick` in every cycle, whatever the divider settings.
- R5: When main word bit 7 is 1, main word bits 3:2 hold the ratio code. Codes 0, 1 and 2 emit one `cpu_tick` on every 1st, 2nd and 3rd selected source pulse respectively.
- R6: With ratio code 3, the divider emits one `cpu_tick` on every 2N-th selected source pulse. N is the 9-bit value in divider word bits 28:20.
- R7: With ratio code 3 and N = 0, the divider passes every selected source pulse, which gives a divide by 1 rather than a stall.
- R8: A new ratio code or N value takes effect only after the period in progress has ended with its output pulse. The first period after the change then uses the new ratio.
- R9: With bit 7 set, `cpu_tick` is asserted only in cycles that carry a pulse from the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | Crystal reference edge pulse |
| pll_tick | input | 1 | PLL reference edge pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` (combinational) |
| cpu_tick | output | 1 | Processor clock edge pulse |

## Verification
On every cycle, the assertions check that divider pulses occur only on selected source pulses and that the period counter stays below the active ratio. They also check that the active ratio changes only at a period boundary and that register writes land in the addressed word. The actual pulse spacing for each ratio code and N value, and the deferral of a change made in mid-period, can be shown only by the bench. It compares every cycle of `cpu_tick` with its own model under random source pulse patterns and random settings, and also runs directed cases for N = 0, the largest N and a change made in mid-period.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;
   typedef enum logic [1:0] {
      RATIO_BY1  = 2'd0,
      RATIO_BY2  = 2'd1,
      RATIO_BY3  = 2'd2,
      RATIO_EVEN = 2'd3
   } ratio_code_e;

   localparam int unsigned OFS_DIV_WORD  = 32'h00;
   localparam int unsigned OFS_MAIN_WORD = 32'h40;
endpackage

// File: rtl/cpu_clk_regs.sv
module cpu_clk_regs #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned OFS_DIV  = 0,
   parameter int unsigned OFS_MAIN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] div_word,
   output logic [DATA_W-1:0] main_word
);
   localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIV);
   localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(OFS_MAIN);

   logic hit_div, hit_main;
   assign hit_div  = (addr == A_DIV);
   assign hit_main = (addr == A_MAIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_word  <= '0;
         main_word <= '0;
      end else if (wr) begin
         if (hit_div)  div_word  <= wdata;
         if (hit_main) main_word <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_div)  rdata = div_word;
      if (hit_main) rdata = main_word;
   end
endmodule

// File: rtl/cpu_clk_divider.sv
module cpu_clk_divider
   import cpu_clk_pkg::*;
#(
   parameter int unsigned N_W   = 9,
   parameter int unsigned CNT_W = N_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic [1:0]       ratio_code,
   input  logic [N_W-1:0]   n_val,
   output logic             div_tick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] active
);
   logic [CNT_W-1:0] next_ratio;
   logic             last;

   always_comb begin
      unique case (ratio_code_e'(ratio_code))
         RATIO_BY1:  next_ratio = CNT_W'(1);
         RATIO_BY2:  next_ratio = CNT_W'(2);
         RATIO_BY3:  next_ratio = CNT_W'(3);
         RATIO_EVEN: next_ratio = (n_val == '0) ? CNT_W'(1) : {n_val, 1'b0};
         default:    next_ratio = CNT_W'(1);
      endcase
   end

   assign last     = (cnt == active - CNT_W'(1));
   assign div_tick = src_tick & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= CNT_W'(1);
      end else if (src_tick) begin
         if (last) begin
            cnt    <= '0;
            active <= next_ratio;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/cpu_clk_path.sv
module cpu_clk_path
   import cpu_clk_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned N_W     = 9,
   parameter int unsigned N_LSB   = 20,
   parameter int unsigned SEL_LSB = 2,
   parameter int unsigned SRC_BIT = 0,
   parameter int unsigned OUT_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xtal_tick,
   input  logic              pll_tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              cpu_tick
);
   localparam int unsigned CNT_W = N_W + 1;

   generate
      if (N_LSB + N_W > DATA_W) begin : g_bad_n
         $error("N field does not fit in the control word");
      end
      if (SEL_LSB + 2 > DATA_W || SRC_BIT >= DATA_W || OUT_BIT >= DATA_W) begin : g_bad_bits
         $error("control bit position outside the control word");
      end
      if (OFS_MAIN_WORD >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the register offsets");
      end
   endgenerate

   logic [DATA_W-1:0] div_word, main_word;
   logic              src_tick, div_tick;
   logic [CNT_W-1:0]  div_cnt, div_active;

   cpu_clk_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .OFS_DIV(OFS_DIV_WORD), .OFS_MAIN(OFS_MAIN_WORD)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .div_word(div_word), .main_word(main_word)
   );

   assign src_tick = main_word[SRC_BIT] ? pll_tick : xtal_tick;

   cpu_clk_divider #(.N_W(N_W), .CNT_W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .ratio_code(main_word[SEL_LSB +: 2]),
      .n_val(div_word[N_LSB +: N_W]),
      .div_tick(div_tick), .cnt(div_cnt), .active(div_active)
   );

   assign cpu_tick = main_word[OUT_BIT] ? div_tick : xtal_tick;
endmodule

// File: rtl/cpu_clk_path_chk.sv
module cpu_clk_path_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned OUT_BIT  = 7,
   parameter int unsigned OFS_DIV  = 0,
   parameter int unsigned OFS_MAIN = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] div_word,
   input logic [DATA_W-1:0] main_word,
   input logic              src_tick,
   input logic              div_tick,
   input logic              cpu_tick,
   input logic [CNT_W-1:0]  div_cnt,
   input logic [CNT_W-1:0]  div_active
);
   AST_DIV_ON_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick |-> src_tick);                                            // R9
   AST_OUT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (main_word[OUT_BIT] && !src_tick) |-> !cpu_tick);                  // R9
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      div_cnt < div_active);                                             // R6
   AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !div_tick |=> $stable(div_active));                                // R8
   AST_DIV_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_DIV)) |=> div_word == $past(reg_wdata)); // R2
   AST_MAIN_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_MAIN)) |=> main_word == $past(reg_wdata)); // R2
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && (reg_addr == ADDR_W'(OFS_DIV) || reg_addr == ADDR_W'(OFS_MAIN)))
      |=> ($stable(div_word) && $stable(main_word)));                    // R2
endmodule

bind cpu_clk_path cpu_clk_path_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OUT_BIT(OUT_BIT),
   .OFS_DIV(cpu_clk_pkg::OFS_DIV_WORD), .OFS_MAIN(cpu_clk_pkg::OFS_MAIN_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .div_word(div_word), .main_word(main_word),
   .src_tick(src_tick), .div_tick(div_tick), .cpu_tick(cpu_tick),
   .div_cnt(div_cnt), .div_active(div_active)
);

// File: tb/tb_cpu_clk_path.sv
module tb_cpu_clk_path;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        xtal_tick = 0, pll_tick = 0, reg_wr = 0;
   logic [7:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        cpu_tick;

   int checks = 0, fails = 0;
   bit done = 0;
   string tag = "R1";
   logic [31:0] m_div = 0, m_main = 0;
   int m_cnt = 0, m_ratio = 1;
   logic obs;

   cpu_clk_path dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int ratio_of(logic [31:0] dw, logic [31:0] mw);
      int sel = int'(mw[3:2]);
      int n = int'(dw[28:20]);
      if (sel < 3) return sel + 1;
      return (n == 0) ? 1 : 2 * n;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare combinational output, update model
   task automatic cycle(bit xt, bit pt, bit we = 0, logic [7:0] a = 0, logic [31:0] d = 0);
      bit src, last, dt, ex;
      xtal_tick = xt; pll_tick = pt; reg_wr = we; reg_addr = a; reg_wdata = d;
      #1;
      src  = m_main[0] ? pt : xt;
      last = (m_cnt == m_ratio - 1);
      dt   = src && last;
      ex   = m_main[7] ? dt : xt;
      obs  = cpu_tick;
      check(cpu_tick == ex, tag, 32'(cpu_tick), 32'(ex));
      if (m_main[7] && cpu_tick) check(src, "R9", 32'(cpu_tick), 32'(src));
      if (src) begin
         if (last) begin m_cnt = 0; m_ratio = ratio_of(m_div, m_main); end
         else m_cnt++;
      end
      if (we && a == 8'h00) m_div = d;
      if (we && a == 8'h40) m_main = d;
      @(negedge clk);
   endtask

   task automatic read_chk(logic [7:0] a, logic [31:0] exp, string req);
      reg_wr = 0; reg_addr = a; #1;
      check(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   // count PLL pulses up to and including the next output pulse
   task automatic pulses_to_tick(output int n);
      n = 0;
      do begin cycle(0, 1); n++; end while (!obs && n < 3000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd20240601));
      @(negedge clk); @(negedge clk);
      read_chk(8'h00, 0, "R1");
      read_chk(8'h40, 0, "R1");
      rst_n = 1;
      @(negedge clk);
      tag = "R1";
      for (int i = 0; i < 20; i++) cycle(i % 3 == 0, 1);
      read_chk(8'h00, 0, "R1");

      // R2: storage of full words, unmapped offsets
      cycle(0, 0, 1, 8'h00, 32'hA5A5_5A5A);
      read_chk(8'h00, 32'hA5A5_5A5A, "R2");
      cycle(0, 0, 1, 8'h40, 32'h1234_0000);
      read_chk(8'h40, 32'h1234_0000, "R2");
      cycle(0, 0, 1, 8'h20, 32'hFFFF_FFFF);
      read_chk(8'h20, 0, "R2");
      read_chk(8'h00, 32'hA5A5_5A5A, "R2");
      read_chk(8'h40, 32'h1234_0000, "R2");

      // R4: bit 7 clear bypasses divider
      tag = "R4";
      cycle(0, 0, 1, 8'h40, 32'h0000_000D);
      for (int i = 0; i < 40; i++) cycle($urandom % 2, $urandom % 2);

      // R5: codes 0..2 from PLL
      tag = "R5";
      for (int c = 0; c < 3; c++) begin
         cycle(0, 0, 1, 8'h40, 32'h81 | 32'(c << 2));
         pulses_to_tick(n);
         pulses_to_tick(n);
         check(n == c + 1, "R5", 32'(n), 32'(c + 1));
      end

      // R6: even divide, N = 5 and largest N
      tag = "R6";
      cycle(0, 0, 1, 8'h00, 32'(5) << 20);
      cycle(0, 0, 1, 8'h40, 32'h8D);
      pulses_to_tick(n); pulses_to_tick(n);
      check(n == 10, "R6", 32'(n), 10);
      cycle(0, 0, 1, 8'h00, 32'(511) << 20);
      pulses_to_tick(n); pulses_to_tick(n);
      check(n == 1022, "R6", 32'(n), 1022);

      // R7: N = 0 behaves as divide by 1
      tag = "R7";
      cycle(0, 0, 1, 8'h00, 32'h0000_0000);
      pulses_to_tick(n); pulses_to_tick(n);
      check(n == 1, "R7", 32'(n), 1);

      // R8: change in mid-period deferred
      tag = "R8";
      cycle(0, 0, 1, 8'h40, 32'h89);           // /3
      pulses_to_tick(n); pulses_to_tick(n);     // at boundary, /3 active
      cycle(0, 1);                              // one pulse into period
      cycle(0, 0, 1, 8'h40, 32'h85);            // request /2
      pulses_to_tick(n);
      check(n == 2, "R8", 32'(n + 1), 3);       // period still length 3
      pulses_to_tick(n);
      check(n == 2, "R8", 32'(n), 2);

      // R3: random settings, sources and densities
      tag = "R3";
      for (int i = 0; i < 20000; i++) begin
         if (i % 97 == 0)
            cycle($urandom % 4 == 0, $urandom % 4 != 0, 1, 8'h00,
                  ($urandom & 32'hE00F_FFFF) | (32'($urandom % 9) << 20));
         else if (i % 89 == 0)
            cycle($urandom % 4 == 0, $urandom % 4 != 0, 1, 8'h40,
                  $urandom | ((i % 3 != 0) ? 32'h80 : 32'h0));
         else
            cycle($urandom % 4 == 0, $urandom % 4 != 0);
      end
      read_chk(8'h00, m_div, "R2");
      read_chk(8'h40, m_main, "R2");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule